// File: doc/BRIEF.md
# Flash program command sequencer

This block sits behind a bus front end that has already decoded host transfers into single byte writes, each carrying an address, a data byte and a valid strobe. It watches that stream for the three-write unlock prefix that arms a flash byte program. Once armed, the next accepted write is taken as the program target. The block latches its full address and data byte, issues a one-clock program-start pulse, and then holds a busy flag for a fixed, parameterised number of clocks. This models the internal program operation. A one-clock done pulse marks the end of busy.

Only the low 16 bits of the address take part in the prefix comparison, because the upper bits are fixed by the decode window that selects the device. Any write that does not fit the expected step sends the sequencer back to its first step. If that write is itself a valid first step, it is counted as one. While busy, every write is dropped and cannot advance the sequence. A synchronous reset returns everything to idle.

Top module: `flash_prog_seq`

## Requirements
- R1: While `rst` is high at a rising edge, the block returns to the first step with `busy`, `done` and `prog_start` low. An unlock prefix that was partly entered before the reset no longer counts.
- R2: The first step is an accepted write of data 0xAA with `wr_addr[15:0]` = 0x5555. Address bits above bit 15 do not affect any step match.
- R3: The second step is data 0x55 with `wr_addr[15:0]` = 0x2AAA.
- R4: The third step is data 0xA0 with `wr_addr[15:0]` = 0x5555. It arms the sequencer.
- R5: When armed, the next accepted write, of any address and data, causes `prog_start` to be high for exactly one clock, starting at the edge that samples that write. In that same clock `prog_addr` and `prog_data` carry that write's full 32-bit address and its data byte.
- R6: An accepted write that does not match the expected step returns the sequencer to the first step.
- R7: A mismatching write that is itself data 0xAA to low address 0x5555 is counted as a completed first step.
- R8: `busy` rises with `prog_start` and stays high for exactly `BUSY_CYCLES` clocks.
- R9: `done` is high for exactly one clock: the first clock after `busy` falls.
- R10: Writes presented while `busy` is high are ignored. They neither advance nor reset the sequence, and they never start a program.
- R11: Clocks with `wr_valid` low leave the sequence where it is, so idle gaps between steps are allowed.
- R12: `prog_addr` and `prog_data` keep the last target until the next program start, including across later non-target writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_valid | input | 1 | Write strobe for the current address and data |
| wr_addr | input | ADDR_W (32) | Write address |
| wr_data | input | 8 | Write data byte |
| prog_start | output | 1 | One-clock program-start pulse |
| prog_addr | output | ADDR_W (32) | Latched target address |
| prog_data | output | 8 | Latched target data |
| busy | output | 1 | Program operation in progress |
| done | output | 1 | One-clock pulse when the program operation ends |

## Verification
The sequencer state, the target latch and the program-start pulse all change at the single rising edge that samples a write. The bench therefore drives each write at a falling edge and reads the response at the next falling edge. From the edge that produces `prog_start`, `busy` is expected high for `BUSY_CYCLES` consecutive falling-edge samples, `done` is expected in the sample after that, and `done` is expected low again in the sample after that. The bench walks through those samples one clock at a time rather than waiting on the design's own signals. Writes that should be ignored are followed by a target write whose lack of a start pulse shows that the sequence did not advance.

// File: rtl/fps_pkg.sv
package fps_pkg;

  typedef enum logic [1:0] {
    ST_WAIT_A = 2'd0,
    ST_WAIT_B = 2'd1,
    ST_WAIT_C = 2'd2,
    ST_ARMED  = 2'd3
  } seq_step_t;

  localparam int          KEY_W     = 16;
  localparam int          BYTE_W    = 8;
  localparam logic [15:0] KEY_ADDR_A = 16'h5555;
  localparam logic [15:0] KEY_ADDR_B = 16'h2AAA;
  localparam logic [7:0]  KEY_DATA_A = 8'hAA;
  localparam logic [7:0]  KEY_DATA_B = 8'h55;
  localparam logic [7:0]  KEY_DATA_C = 8'hA0;

  function automatic logic key_match(input logic [KEY_W-1:0] a, input logic [BYTE_W-1:0] d,
                                     input logic [KEY_W-1:0] ka, input logic [BYTE_W-1:0] kd);
    return (a == ka) && (d == kd);
  endfunction

  function automatic logic is_first_step(input logic [KEY_W-1:0] a, input logic [BYTE_W-1:0] d);
    return key_match(a, d, KEY_ADDR_A, KEY_DATA_A);
  endfunction

  function automatic seq_step_t next_step(input seq_step_t cur, input logic [KEY_W-1:0] a,
                                          input logic [BYTE_W-1:0] d);
    seq_step_t fallback;
    fallback = is_first_step(a, d) ? ST_WAIT_B : ST_WAIT_A;
    case (cur)
      ST_WAIT_A: return fallback;
      ST_WAIT_B: return key_match(a, d, KEY_ADDR_B, KEY_DATA_B) ? ST_WAIT_C : fallback;
      ST_WAIT_C: return key_match(a, d, KEY_ADDR_A, KEY_DATA_C) ? ST_ARMED : fallback;
      default:   return ST_WAIT_A;
    endcase
  endfunction

endpackage

// File: rtl/fps_unlock.sv
module fps_unlock
  import fps_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_valid,
  input  logic [KEY_W-1:0]  key_addr,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic              busy,
  output logic              accept,
  output logic              tgt_hit,
  output seq_step_t         step
);

  seq_step_t step_q;

  assign accept  = wr_valid && !busy;
  assign tgt_hit = accept && (step_q == ST_ARMED);
  assign step    = step_q;

  always_ff @(posedge clk) begin
    if (rst)
      step_q <= ST_WAIT_A;
    else if (accept)
      step_q <= next_step(step_q, key_addr, wr_data);
  end

  // R10: a busy cycle never moves the sequence
  a_r10_hold_when_busy: assert property (@(posedge clk) disable iff (rst)
    busy |=> (step_q == $past(step_q)));

  // R11: idle cycles hold the sequence
  a_r11_idle_hold: assert property (@(posedge clk) disable iff (rst)
    !wr_valid |=> (step_q == $past(step_q)));

  // R5: using up the armed state returns to the first step
  a_r5_armed_consumed: assert property (@(posedge clk) disable iff (rst)
    tgt_hit |=> (step_q == ST_WAIT_A));

  // R7: a first-step pair always leaves the sequencer waiting for step two
  a_r7_restart: assert property (@(posedge clk) disable iff (rst)
    (accept && step_q != ST_ARMED && key_addr == 16'h5555 && wr_data == 8'hAA)
      |=> (step_q == ST_WAIT_B));

endmodule

// File: rtl/fps_target.sv
module fps_target
  import fps_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [BYTE_W-1:0] wr_data,
  output logic              prog_start,
  output logic [ADDR_W-1:0] prog_addr,
  output logic [BYTE_W-1:0] prog_data
);

  always_ff @(posedge clk) begin
    if (rst) begin
      prog_start <= 1'b0;
      prog_addr  <= '0;
      prog_data  <= '0;
    end else begin
      prog_start <= load;
      if (load) begin
        prog_addr <= wr_addr;
        prog_data <= wr_data;
      end
    end
  end

  // R12: the latched target only changes on a load
  a_r12_target_held: assert property (@(posedge clk) disable iff (rst)
    !load |=> ($stable(prog_addr) && $stable(prog_data)));

endmodule

// File: rtl/fps_timer.sv
module fps_timer #(
  parameter int BUSY_CYCLES = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic busy,
  output logic done
);

  localparam int CNT_W = $clog2(BUSY_CYCLES + 1);

  logic [CNT_W-1:0] cnt;

  function automatic logic [CNT_W-1:0] cnt_next(input logic [CNT_W-1:0] cur, input logic ld);
    if (ld)
      return CNT_W'(BUSY_CYCLES);
    else if (cur != '0)
      return cur - CNT_W'(1);
    else
      return cur;
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      done <= 1'b0;
    end else begin
      cnt  <= cnt_next(cnt, start);
      done <= (cnt == CNT_W'(1)) && !start;
    end
  end

  assign busy = (cnt != '0);

  // R8: a start raises busy at the next edge
  a_r8_start_busy: assert property (@(posedge clk) disable iff (rst)
    start |=> busy);

  // R8: no start can arrive while a program runs
  a_r8_no_restart: assert property (@(posedge clk) disable iff (rst)
    busy |-> !start);

  // R9: done comes right after the busy window closes
  a_r9_done_after_busy: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && $past(busy)));

  // R9: done lasts one clock
  a_r9_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

endmodule

// File: rtl/flash_prog_seq.sv
module flash_prog_seq
  import fps_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int BUSY_CYCLES = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_valid,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  output logic              prog_start,
  output logic [ADDR_W-1:0] prog_addr,
  output logic [7:0]        prog_data,
  output logic              busy,
  output logic              done
);

  logic      accept;
  logic      tgt_hit;
  seq_step_t step;

  fps_unlock u_unlock (
    .clk      (clk),
    .rst      (rst),
    .wr_valid (wr_valid),
    .key_addr (wr_addr[KEY_W-1:0]),
    .wr_data  (wr_data),
    .busy     (busy),
    .accept   (accept),
    .tgt_hit  (tgt_hit),
    .step     (step)
  );

  fps_target #(.ADDR_W(ADDR_W)) u_target (
    .clk        (clk),
    .rst        (rst),
    .load       (tgt_hit),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .prog_start (prog_start),
    .prog_addr  (prog_addr),
    .prog_data  (prog_data)
  );

  fps_timer #(.BUSY_CYCLES(BUSY_CYCLES)) u_timer (
    .clk   (clk),
    .rst   (rst),
    .start (tgt_hit),
    .busy  (busy),
    .done  (done)
  );

  // R5: program start is a single-clock pulse
  a_r5_pulse_one_clk: assert property (@(posedge clk) disable iff (rst)
    prog_start |=> !prog_start);

  // R8: busy is already high in the start clock
  a_r8_busy_with_start: assert property (@(posedge clk) disable iff (rst)
    prog_start |-> busy);

  // R1: reset clears the outputs at the next edge
  a_r1_reset_clear: assert property (@(posedge clk)
    rst |=> (!busy && !done && !prog_start && step == ST_WAIT_A));

endmodule

// File: tb/sim_flash_prog_seq.sv
module sim_flash_prog_seq;

  localparam int BUSY = 6;
  localparam int NV   = 29;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_valid = 1'b0;
  logic [31:0] wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic        prog_start, busy, done;
  logic [31:0] prog_addr;
  logic [7:0]  prog_data;

  int checks = 0;
  int errors = 0;
  bit ended  = 0;

  always #4 clk = ~clk;

  flash_prog_seq #(.ADDR_W(32), .BUSY_CYCLES(BUSY)) u0 (
    .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data),
    .prog_start(prog_start), .prog_addr(prog_addr), .prog_data(prog_data),
    .busy(busy), .done(done)
  );

  // {expect_start, address, data}
  localparam logic [40:0] VEC [NV] = '{
    {1'b0, 32'h0000_5555, 8'hAA},  // R2
    {1'b0, 32'h0000_2AAA, 8'h55},  // R3
    {1'b0, 32'h0000_5555, 8'hA0},  // R4
    {1'b1, 32'hFFC0_1234, 8'h3C},  // R5
    {1'b0, 32'hFFFF_5555, 8'hAA},  // R2 upper bits ignored
    {1'b0, 32'hFFFF_2AAA, 8'h55},
    {1'b0, 32'hFFFF_5555, 8'hA0},
    {1'b1, 32'h000E_0000, 8'h00},
    {1'b0, 32'h0000_5555, 8'hAA},
    {1'b0, 32'h0000_2AAA, 8'h56},  // R6 data mismatch
    {1'b0, 32'h0000_5555, 8'hA0},
    {1'b0, 32'h0000_1111, 8'h11},  // R6 no start
    {1'b0, 32'h0000_5555, 8'hAA},
    {1'b0, 32'h0000_5555, 8'hAA},  // R7 restart at step two
    {1'b0, 32'h0000_2AAA, 8'h55},
    {1'b0, 32'h0000_5555, 8'hA0},
    {1'b1, 32'hFFFF_FFFF, 8'h77},
    {1'b0, 32'h0000_5555, 8'hAA},
    {1'b0, 32'h0000_2AAB, 8'h55},  // R6 address mismatch
    {1'b0, 32'h0000_5555, 8'hAA},
    {1'b0, 32'h0000_2AAA, 8'h55},
    {1'b0, 32'h0000_5555, 8'hA0},
    {1'b1, 32'h000F_FFFF, 8'h5A},
    {1'b0, 32'h0000_5555, 8'hAA},
    {1'b0, 32'h0000_2AAA, 8'h55},
    {1'b0, 32'h0000_5555, 8'hAA},  // R7 restart at step three
    {1'b0, 32'h0000_2AAA, 8'h55},
    {1'b0, 32'h0000_5555, 8'hA0},
    {1'b1, 32'h0000_5555, 8'hC3}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [31:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_valid = 1'b1;
    wr_addr  = a;
    wr_data  = d;
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic prefix();
    wr(32'h0000_5555, 8'hAA);
    wr(32'h0000_2AAA, 8'h55);
    wr(32'h0000_5555, 8'hA0);
  endtask

  // called at the falling edge right after the target write was sampled
  task automatic check_run(input logic [31:0] a, input logic [7:0] d, input string tag);
    chk({tag, " R5 prog_start"}, 32'(prog_start), 32'd1);
    chk({tag, " R5 prog_addr"}, prog_addr, a);
    chk({tag, " R5 prog_data"}, 32'(prog_data), 32'(d));
    chk({tag, " R8 busy at start"}, 32'(busy), 32'd1);
    for (int k = 1; k < BUSY; k++) begin
      @(negedge clk);
      chk({tag, " R8 busy held"}, {prog_start, busy, done}, 3'b010);
    end
    @(negedge clk);
    chk({tag, " R9 done after busy"}, {busy, done}, 2'b01);
    @(negedge clk);
    chk({tag, " R9 done single"}, 32'(done), 32'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!ended) begin
      ended = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    idle(3);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 reset outputs", {prog_start, busy, done}, 3'b000);

    for (int i = 0; i < NV; i++) begin
      wr(VEC[i][39:8], VEC[i][7:0]);
      if (VEC[i][40])
        check_run(VEC[i][39:8], VEC[i][7:0], $sformatf("vec%0d", i));
      else
        chk($sformatf("vec%0d R6 no start", i), 32'(prog_start), 32'd0);
    end

    // R11: idle gaps between steps
    wr(32'h0000_5555, 8'hAA); idle(3);
    wr(32'h0000_2AAA, 8'h55); idle(5);
    wr(32'h0000_5555, 8'hA0); idle(2);
    wr(32'h1234_5678, 8'h9E);
    check_run(32'h1234_5678, 8'h9E, "R11 gaps");

    // R12: target held across unrelated writes
    wr(32'h0000_0001, 8'h01);
    wr(32'h0000_5555, 8'hAA);
    chk("R12 addr held", prog_addr, 32'h1234_5678);
    chk("R12 data held", 32'(prog_data), 32'h9E);
    wr(32'h0000_0000, 8'h00);   // clears the partial prefix (R6)

    // R10: writes during busy ignored
    prefix();
    wr(32'hABCD_0000, 8'h42);
    chk("R10 start", 32'(prog_start), 32'd1);
    wr(32'h0000_5555, 8'hAA);
    chk("R10 busy ignores", {prog_start, busy}, 2'b01);
    wr(32'h0000_2AAA, 8'h55);
    wr(32'h0000_5555, 8'hA0);
    chk("R10 addr unchanged", prog_addr, 32'hABCD_0000);
    while (busy) @(negedge clk);
    chk("R9 done seen", 32'(done), 32'd1);
    wr(32'h0000_9999, 8'h99);
    chk("R10 no start after busy", 32'(prog_start), 32'd0);
    chk("R10 no busy after busy", 32'(busy), 32'd0);

    // R1: reset mid-prefix
    wr(32'h0000_5555, 8'hAA);
    wr(32'h0000_2AAA, 8'h55);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    wr(32'h0000_5555, 8'hA0);
    wr(32'h0000_7777, 8'h77);
    chk("R1 prefix lost", 32'(prog_start), 32'd0);

    // R1: reset during busy
    prefix();
    wr(32'h0000_0042, 8'h24);
    chk("R1 pre busy", 32'(busy), 32'd1);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    chk("R1 busy cleared", {prog_start, busy, done}, 3'b000);
    idle(BUSY + 2);
    chk("R1 no done after reset", 32'(done), 32'd0);

    // R2..R5 once more after reset
    prefix();
    wr(32'h8000_0003, 8'hE1);
    check_run(32'h8000_0003, 8'hE1, "R4 after reset");

    if (!ended) begin
      ended = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule